// File: doc/BRIEF.md
# Camera power-up and register configurator

This block takes an image sensor from power-down to a configured state with no help from software. After the chip reset is released it first lowers the sensor's power-down pin, keeps the sensor's active-low reset pin asserted for a programmed number of clocks, then releases it. A second programmed delay gives the sensor time to boot. The block then writes a fixed list of register settings over the two-wire SCCB serial bus.

Each write is a complete bus transaction. It sends the device ID byte, the two bytes of a 16-bit register address and one data byte. After every byte the data line is released for one slot, and no acknowledge is checked. The settings table is generated inside the block from its index. The block walks the table once, in order, and then raises a done flag that stays high until the next reset. The serial data pin is driven through an output-enable pair, so the pad sits in high impedance whenever the block releases the line. An external pull-up is assumed to hold the released line high.

Top module: `cam_init_ctrl`

## Requirements
- R1: While rst_n is low: cam_pwdn = 1, cam_resetb = 0, sccb_clk = 1, sccb_data_oe = 0 and config_done = 0.
- R2: cam_pwdn falls at the first clock edge after rst_n is released and never rises again until the next reset.
- R3: cam_resetb stays low for exactly RST_DLY clocks after cam_pwdn falls. It then goes high and stays high, and it is never high while cam_pwdn is high.
- R4: The bus stays idle (sccb_clk = 1 and sccb_data_oe = 0) from reset until BOOT_DLY + 2 clocks after cam_resetb rises. The first write begins at that point.
- R5: Every SIOC period is 4*QTR_CYC clocks, split into quarters of QTR_CYC clocks. A write is 39 periods long:
  - a start period, in which SIOC is high for three quarters and low for the last, and SIOD is high for two quarters and then low;
  - 36 bit periods, in which SIOC is low, high, high, low across the quarters and SIOD holds one value for the whole period;
  - a stop period, in which SIOC is low for the first quarter and then high, and SIOD is low for two quarters and then high;
  - a guard period with SIOC high and SIOD released.
- R6: The 36 bit periods carry four bytes, each sent most-significant bit first and followed by one period with sccb_data_oe = 0. The bytes are, in order: DEV_ID (0x78), the address high byte, the address low byte, and the data byte. Entry i has address ADDR_BASE + i (0x3000 + i by default) and data (i mod 256) XOR 0xA5.
- R7: SIOD and its enable never change on the clock edge where SIOC rises or falls. Outside the start and stop periods, SIOD changes only while SIOC is low.
- R8: Consecutive writes are separated by the guard period plus 2 idle clocks, so write starts are exactly 156*QTR_CYC + 2 clocks apart.
- R9: Entries 0 to N_REGS-1 (304 by default) are each written exactly once, in increasing index order.
- R10: config_done rises one clock after the guard period of the last write ends. It then stays high, and the bus stays idle for as long as it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_pwdn | output | 1 | Sensor power-down, active high |
| cam_resetb | output | 1 | Sensor reset, active low |
| sccb_clk | output | 1 | Serial bus clock (SIOC) |
| sccb_data_o | output | 1 | Serial data value driven when enabled |
| sccb_data_oe | output | 1 | Serial data output enable; pad is high impedance when 0 |
| config_done | output | 1 | All table entries written; sticky |

## Verification
The bench keeps the full 304-entry table and DEV_ID 0x78. It shortens only the timing: QTR_CYC = 2, RST_DLY = 40 and BOOT_DLY = 100. Each write then takes 314 clocks, so every entry, the wrap of the data byte's index past 255, and the final done edge all fall within a single run. At these settings the bench can compare the power pins and every quarter-period of every transaction against its model. It also decodes the bus on SIOC falling edges, as the sensor would.

// File: rtl/cam_cfg_pkg.sv
package cam_cfg_pkg;

    // Bus pin state produced by the write engine
    typedef struct packed {
        logic sioc;
        logic sda_o;
        logic sda_oe;
    } sccb_pins_t;

    localparam sccb_pins_t BUS_IDLE = '{sioc: 1'b1, sda_o: 1'b1, sda_oe: 1'b0};

    localparam int PAYLOAD_W      = 32;
    localparam int SLOTS_PER_BYTE = 9;
    localparam int BYTES_PER_WR   = 4;
    localparam int BIT_SLOTS      = SLOTS_PER_BYTE * BYTES_PER_WR;  // 36
    localparam int STOP_SLOT      = BIT_SLOTS + 1;                  // 37
    localparam int GUARD_SLOT     = BIT_SLOTS + 2;                  // 38

    // Settings table generator: address and data from entry index
    function automatic logic [15:0] tbl_addr(logic [15:0] base, int unsigned idx);
        return base + 16'(idx);
    endfunction

    function automatic logic [7:0] tbl_data(int unsigned idx);
        return 8'(idx) ^ 8'hA5;
    endfunction

endpackage

// File: rtl/cam_pwr_seq.sv
module cam_pwr_seq #(
    parameter int RST_DLY  = 25000,
    parameter int BOOT_DLY = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic pwdn,
    output logic resetb,
    output logic ready
);
    localparam int MAX_DLY = (RST_DLY > BOOT_DLY) ? RST_DLY : BOOT_DLY;
    localparam int CNT_W   = $clog2(MAX_DLY + 1);

    typedef enum logic [1:0] {P_OFF, P_HOLD, P_BOOT, P_RDY} pstage_e;

    typedef struct packed {
        pstage_e          stage;
        logic [CNT_W-1:0] cnt;
        logic             pwdn;
        logic             resetb;
    } pwr_t;

    pwr_t d, q;

    always_comb begin
        d = q;
        case (q.stage)
            P_OFF: begin
                d.pwdn  = 1'b0;
                d.stage = P_HOLD;
                d.cnt   = '0;
            end
            P_HOLD: begin
                if (q.cnt == CNT_W'(RST_DLY - 1)) begin
                    d.resetb = 1'b1;
                    d.stage  = P_BOOT;
                    d.cnt    = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            P_BOOT: begin
                if (q.cnt == CNT_W'(BOOT_DLY - 1)) begin
                    d.stage = P_RDY;
                    d.cnt   = '0;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{stage: P_OFF, cnt: '0, pwdn: 1'b1, resetb: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign pwdn   = q.pwdn;
    assign resetb = q.resetb;
    assign ready  = (q.stage == P_RDY);

endmodule

// File: rtl/cam_cfg_table.sv
module cam_cfg_table
    import cam_cfg_pkg::*;
#(
    parameter int          IDX_W     = 9,
    parameter logic [7:0]  DEV_ID    = 8'h78,
    parameter logic [15:0] ADDR_BASE = 16'h3000
) (
    input  logic [IDX_W-1:0]     idx,
    output logic [PAYLOAD_W-1:0] payload
);
    always_comb begin
        payload = {DEV_ID, tbl_addr(ADDR_BASE, 32'(idx)), tbl_data(32'(idx))};
    end
endmodule

// File: rtl/sccb_wr_engine.sv
module sccb_wr_engine
    import cam_cfg_pkg::*;
#(
    parameter int QTR_CYC = 63
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [PAYLOAD_W-1:0] payload,
    output logic                 sioc,
    output logic                 sda_o,
    output logic                 sda_oe,
    output logic                 fin
);
    localparam int DIV_W = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

    typedef struct packed {
        logic                 busy;
        logic [5:0]           slot;
        logic [1:0]           ph;
        logic [DIV_W-1:0]     div;
        logic [PAYLOAD_W-1:0] word;
        logic                 fin;
        sccb_pins_t           pins;
    } eng_t;

    eng_t d, q;

    // Pin values for one quarter of one slot
    function automatic sccb_pins_t slot_pins(logic [5:0] slot, logic [1:0] ph,
                                             logic [PAYLOAD_W-1:0] w);
        sccb_pins_t p;
        int b, byt, pos;
        p = BUS_IDLE;
        if (slot == 6'd0) begin
            p.sioc   = (ph != 2'd3);
            p.sda_o  = (ph < 2'd2);
            p.sda_oe = 1'b1;
        end else if (slot == 6'(STOP_SLOT)) begin
            p.sioc   = (ph != 2'd0);
            p.sda_o  = (ph >= 2'd2);
            p.sda_oe = 1'b1;
        end else if (slot == 6'(GUARD_SLOT)) begin
            p = BUS_IDLE;
        end else begin
            b   = int'(slot) - 1;
            byt = b / SLOTS_PER_BYTE;
            pos = b % SLOTS_PER_BYTE;
            p.sioc = (ph == 2'd1) || (ph == 2'd2);
            if (pos == SLOTS_PER_BYTE - 1) begin
                p.sda_o  = 1'b1;
                p.sda_oe = 1'b0;
            end else begin
                p.sda_o  = w[PAYLOAD_W - 1 - byt * 8 - pos];
                p.sda_oe = 1'b1;
            end
        end
        return p;
    endfunction

    always_comb begin
        d     = q;
        d.fin = 1'b0;
        if (!q.busy) begin
            if (start) begin
                d.busy = 1'b1;
                d.slot = '0;
                d.ph   = '0;
                d.div  = '0;
                d.word = payload;
            end
        end else if (q.div == DIV_W'(QTR_CYC - 1)) begin
            d.div = '0;
            d.ph  = q.ph + 1'b1;
            if (q.ph == 2'd3) begin
                if (q.slot == 6'(GUARD_SLOT)) begin
                    d.busy = 1'b0;
                    d.fin  = 1'b1;
                end else begin
                    d.slot = q.slot + 1'b1;
                end
            end
        end else begin
            d.div = q.div + 1'b1;
        end
        d.pins = d.busy ? slot_pins(d.slot, d.ph, d.word) : BUS_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{busy: 1'b0, slot: '0, ph: '0, div: '0, word: '0,
                   fin: 1'b0, pins: BUS_IDLE};
        end else begin
            q <= d;
        end
    end

    assign sioc   = q.pins.sioc;
    assign sda_o  = q.pins.sda_o;
    assign sda_oe = q.pins.sda_oe;
    assign fin    = q.fin;

endmodule

// File: rtl/cam_init_ctrl.sv
module cam_init_ctrl
    import cam_cfg_pkg::*;
#(
    parameter int          N_REGS    = 304,
    parameter logic [7:0]  DEV_ID    = 8'h78,
    parameter logic [15:0] ADDR_BASE = 16'h3000,
    parameter int          QTR_CYC   = 63,
    parameter int          RST_DLY   = 25000,
    parameter int          BOOT_DLY  = 500000
) (
    input  logic clk,
    input  logic rst_n,
    output logic cam_pwdn,
    output logic cam_resetb,
    output logic sccb_clk,
    output logic sccb_data_o,
    output logic sccb_data_oe,
    output logic config_done
);
    localparam int IDX_W = (N_REGS > 1) ? $clog2(N_REGS) : 1;

    typedef enum logic [1:0] {C_WAIT, C_LAUNCH, C_BUSY, C_FIN} ctl_e;

    typedef struct packed {
        ctl_e             ctl;
        logic [IDX_W-1:0] idx;
        logic             done;
    } top_t;

    top_t d, q;

    logic                 pwr_ready;
    logic                 wr_fin;
    logic                 wr_start;
    logic [PAYLOAD_W-1:0] wr_payload;
    logic [IDX_W-1:0]     wr_idx;

    cam_pwr_seq #(.RST_DLY(RST_DLY), .BOOT_DLY(BOOT_DLY)) u_pwr (
        .clk    (clk),
        .rst_n  (rst_n),
        .pwdn   (cam_pwdn),
        .resetb (cam_resetb),
        .ready  (pwr_ready)
    );

    cam_cfg_table #(.IDX_W(IDX_W), .DEV_ID(DEV_ID), .ADDR_BASE(ADDR_BASE)) u_tbl (
        .idx     (wr_idx),
        .payload (wr_payload)
    );

    sccb_wr_engine #(.QTR_CYC(QTR_CYC)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (wr_start),
        .payload (wr_payload),
        .sioc    (sccb_clk),
        .sda_o   (sccb_data_o),
        .sda_oe  (sccb_data_oe),
        .fin     (wr_fin)
    );

    always_comb begin
        d = q;
        case (q.ctl)
            C_WAIT:   if (pwr_ready) d.ctl = C_LAUNCH;
            C_LAUNCH: d.ctl = C_BUSY;
            C_BUSY: begin
                if (wr_fin) begin
                    if (q.idx == IDX_W'(N_REGS - 1)) begin
                        d.ctl  = C_FIN;
                        d.done = 1'b1;
                    end else begin
                        d.idx = q.idx + 1'b1;
                        d.ctl = C_LAUNCH;
                    end
                end
            end
            default: d = q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{ctl: C_WAIT, idx: '0, done: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign wr_start    = (q.ctl == C_LAUNCH);
    assign wr_idx      = q.idx;
    assign config_done = q.done;

endmodule

// File: rtl/cam_init_ctrl_chk.sv
module cam_init_ctrl_chk #(
    parameter int N_REGS = 304,
    parameter int IDX_W  = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cam_pwdn,
    input logic             cam_resetb,
    input logic             sccb_clk,
    input logic             sccb_data_o,
    input logic             sccb_data_oe,
    input logic             config_done,
    input logic [IDX_W-1:0] idx
);
    assert_pwdn_stays_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$rose(cam_pwdn));

    assert_resetb_needs_pwdn_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cam_resetb |-> !cam_pwdn);

    assert_resetb_no_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$fell(cam_resetb));

    assert_bus_quiet_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cam_resetb |-> (sccb_clk && !sccb_data_oe));

    assert_data_stable_at_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sccb_clk) |-> ($stable(sccb_data_o) && $stable(sccb_data_oe)));

    assert_data_stable_at_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sccb_clk) |-> ($stable(sccb_data_o) && $stable(sccb_data_oe)));

    assert_index_in_table_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(idx) < N_REGS);

    assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        config_done |=> config_done);

    assert_done_bus_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        config_done |-> (sccb_clk && !sccb_data_oe));

endmodule

bind cam_init_ctrl cam_init_ctrl_chk #(.N_REGS(N_REGS), .IDX_W(IDX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cam_pwdn     (cam_pwdn),
    .cam_resetb   (cam_resetb),
    .sccb_clk     (sccb_clk),
    .sccb_data_o  (sccb_data_o),
    .sccb_data_oe (sccb_data_oe),
    .config_done  (config_done),
    .idx          (wr_idx)
);

// File: tb/cam_init_ctrl_test.sv
module cam_init_ctrl_test;
    localparam int Q       = 2;
    localparam int RD      = 40;
    localparam int BD      = 100;
    localparam int NR      = 304;
    localparam int SLOT    = 4 * Q;
    localparam int FRAME   = 39 * SLOT;
    localparam int PER     = FRAME + 2;
    localparam int FIRST   = RD + BD + 2;
    localparam int DONE_AT = FIRST + (NR - 1) * PER + FRAME + 1;
    localparam int END_N   = DONE_AT + 400;

    logic clk = 1'b0;
    logic rst_n;
    logic pwdn, resetb, sioc, sda_o, sda_oe, done;

    always #5 clk = ~clk;

    cam_init_ctrl #(
        .N_REGS(NR), .DEV_ID(8'h78), .ADDR_BASE(16'h3000),
        .QTR_CYC(Q), .RST_DLY(RD), .BOOT_DLY(BD)
    ) uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cam_pwdn     (pwdn),
        .cam_resetb   (resetb),
        .sccb_clk     (sioc),
        .sccb_data_o  (sda_o),
        .sccb_data_oe (sda_oe),
        .config_done  (done)
    );

    int checks   = 0;
    int fails    = 0;
    bit finished = 1'b0;

    task automatic chk(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Expected {sioc, oe, line} after edge n, line = pulled-up bus level
    function automatic logic [2:0] exp_bus(int n);
        int rel, k, off, slot, ph, b, byt, pos;
        logic [31:0] w;
        logic c;
        if (n < FIRST) return 3'b101;
        rel = n - FIRST;
        k   = rel / PER;
        off = rel % PER;
        if (k >= NR || off >= FRAME) return 3'b101;
        slot = off / SLOT;
        ph   = (off / Q) % 4;
        w    = {8'h78, 16'h3000 + 16'(k), 8'(k) ^ 8'hA5};
        if (slot == 0)  return {ph != 3, 1'b1, ph < 2};
        if (slot == 37) return {ph != 0, 1'b1, ph >= 2};
        if (slot == 38) return 3'b101;
        b   = slot - 1;
        byt = b / 9;
        pos = b % 9;
        c   = (ph == 1) || (ph == 2);
        if (pos == 8) return {c, 1'b0, 1'b1};
        return {c, 1'b1, w[31 - byt * 8 - pos]};
    endfunction

    function automatic string region_tag(int n);
        int rel;
        if (n < FIRST) return "R4";
        rel = n - FIRST;
        if (rel / PER >= NR) return "R10";
        if (rel % PER < FRAME) return "R5";
        return "R8";
    endfunction

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        bit prev_c, prev_l, cur_l, in_fr, skip;
        int nbits, frames;
        logic [35:0] bits;
        logic [31:0] got, want;
        logic [3:0]  ninth;

        prev_c = 1'b1; prev_l = 1'b1; in_fr = 1'b0; skip = 1'b0;
        nbits = 0; frames = 0; bits = '0;

        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(pwdn == 1'b1,   "R1 pwdn in reset",   36'(pwdn),   36'h1);
        chk(resetb == 1'b0, "R1 resetb in reset", 36'(resetb), 36'h0);
        chk(sioc == 1'b1,   "R1 sioc in reset",   36'(sioc),   36'h1);
        chk(sda_oe == 1'b0, "R1 oe in reset",     36'(sda_oe), 36'h0);
        chk(done == 1'b0,   "R1 done in reset",   36'(done),   36'h0);
        rst_n = 1'b1;

        for (int n = 0; n <= END_N; n++) begin
            @(negedge clk);
            cur_l = sda_oe ? sda_o : 1'b1;
            // power pins (R2, R3) and done flag (R10)
            chk({pwdn, resetb} == {1'b0, n >= RD}, (n < RD) ? "R2 pins" : "R3 pins",
                36'({pwdn, resetb}), 36'({1'b0, n >= RD}));
            chk(done == (n >= DONE_AT), "R10 done flag", 36'(done), 36'(n >= DONE_AT));
            chk({sioc, sda_oe, cur_l} == exp_bus(n), region_tag(n),
                36'({sioc, sda_oe, cur_l}), 36'(exp_bus(n)));

            // receiver-side decode, sampling on SIOC falling edges
            if (prev_c && sioc && prev_l && !cur_l) begin
                in_fr = 1'b1; skip = 1'b1; nbits = 0; bits = '0;
            end else if (prev_c && !sioc && in_fr) begin
                if (skip) skip = 1'b0;
                else begin
                    if (nbits < 36) bits[35 - nbits] = cur_l;
                    nbits++;
                end
            end else if (prev_c && sioc && !prev_l && cur_l && in_fr) begin
                in_fr = 1'b0;
                chk(nbits == 36, "R5 bit count", 36'(nbits), 36'd36);
                got = '0; ninth = '0;
                for (int j = 0; j < 4; j++) begin
                    got   = {got[23:0], bits[35 - j * 9 -: 8]};
                    ninth = {ninth[2:0], bits[35 - j * 9 - 8]};
                end
                want = {8'h78, 16'h3000 + 16'(frames), 8'(frames) ^ 8'hA5};
                chk(got == want, "R6 payload", 36'(got), 36'(want));
                chk(ninth == 4'hF, "R6 ninth released", 36'(ninth), 36'hF);
                frames++;
            end
            prev_c = sioc;
            prev_l = cur_l;
        end
        chk(frames == NR, "R9 write count", 36'(frames), 36'(NR));
        chk(done == 1'b1, "R10 final done", 36'(done), 36'h1);
        finished = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual done=%0d expected run completed", done);
            summary();
            $finish;
        end
    end

endmodule